// File: doc/BRIEF.md
# Complementary Dead-Time Gate Controller

This block turns a single PWM command into enables for two complementary switches: a main switch and an auxiliary switch. It handles the two edges of the command differently. When the command rises, the auxiliary switch is released at once. The main switch turns on only after a programmed dead time. When the command falls, the main switch turns off at once. The auxiliary switch turns back on only after a second, independently programmed dead time. Both dead times are counted in clock cycles and read from register inputs.

Each dead time has its own zero-voltage-detect input. When that input is high, the pending wait ends early and the waiting switch turns on without finishing the count. An enable input puts the block to sleep. In sleep the main switch is held off and the auxiliary driver's output-enable is withdrawn. A build-time parameter selects the auxiliary pin sense: the same sense as the auxiliary switch state for an n-channel switch, or the opposite sense for a p-channel switch.

The PWM, enable and both detect inputs pass through synchronizers before use. Edges are found on the synchronized PWM level. A rising edge is therefore acted on at the third clock edge after the pin changes.

Top module: `cdt_gate_ctrl`

## Requirements
- R1: A rising PWM edge turns the auxiliary switch off 3 clock edges after the pin changes. The main switch turns on `t1_cycles` clock edges after that, so the main dead time equals `t1_cycles` cycles.
- R2: A falling PWM edge turns the main switch off 3 clock edges after the pin changes. The auxiliary switch turns on `t2_cycles` clock edges after that.
- R3: The value of `t1_cycles` or `t2_cycles` is sampled at the edge that starts the wait. A later change does not alter the wait already running, and it applies from the next interval on.
- R4: While `zvs_main` is high during a main wait, the main switch turns on 3 clock edges after `zvs_main` rises, whatever count remains.
- R5: While `zvs_aux` is high during an auxiliary wait, the auxiliary switch turns on 3 clock edges after `zvs_aux` rises.
- R6: Taking `en_in` low makes `main_on` low and `aux_oe` low 3 clock edges later. While `en_in` stays low, PWM activity has no effect on any output.
- R7: With `AUX_INV`=0, `aux_drv` is 1 when the auxiliary switch is on. With `AUX_INV`=1, `aux_drv` is the inverse. When the auxiliary switch is off (including in sleep), `aux_drv` equals `AUX_INV`.
- R8: If the PWM command falls while a main wait is running, the main switch never turns on. The auxiliary wait starts from that falling edge.
- R9: If the PWM command rises while an auxiliary wait is running, the auxiliary switch stays off. The main wait starts from that rising edge.
- R10: A programmed dead time of 0 turns the waiting switch on in the same cycle as the other switch turns off, which is the cycle after the edge is detected.
- R11: After reset, and 3 clock edges after `en_in` returns high, both switches are off with `aux_oe` high. Both stay off until the next PWM edge, even when the PWM level is already high.
- R12: The main and auxiliary switches are never on in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | PWM command, asynchronous |
| en_in | input | 1 | Enable; low selects sleep |
| zvs_main | input | 1 | Zero-voltage detect that ends the main wait |
| zvs_aux | input | 1 | Zero-voltage detect that ends the auxiliary wait |
| t1_cycles | input | CNT_W | Dead time before main turn-on, in cycles |
| t2_cycles | input | CNT_W | Dead time before auxiliary turn-on, in cycles |
| main_on | output | 1 | Main switch enable |
| aux_drv | output | 1 | Auxiliary drive level, sense chosen by AUX_INV |
| aux_oe | output | 1 | Auxiliary driver output-enable; low in sleep |

## Verification
The assertions assume that the synchronized PWM level changes only through detected edges once the edge detector has settled after reset. They also assume that the detect inputs are only meaningful while a wait is running.

The stimulus changes every input on the falling clock edge and holds the PWM level long enough for each wait to end, except in the deliberate early-edge cases. It raises a detect input only after a wait has begun and drops it once the switch is on, well before the next PWM edge.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_T1,
    ST_MAIN,
    ST_T2,
    ST_AUX,
    ST_SLEEP
  } cdt_state_e;

  // A wait is skipped when its count is zero or the detect input is already high.
  function automatic logic dly_skip(input logic cnt_nonzero, input logic zvs);
    return !cnt_nonzero || zvs;
  endfunction

  // Pin level for the auxiliary driver given the switch state and polarity.
  function automatic logic aux_pin(input logic act, input logic inv);
    return act ^ inv;
  endfunction

endpackage

// File: rtl/cdt_sync.sv
module cdt_sync #(
  parameter int unsigned W       = 4,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[g] <= RST_VAL;
        else        pipe[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[g] <= RST_VAL;
        else        pipe[g] <= pipe[g-1];
      end
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/cdt_edge.sv
module cdt_edge #(
  parameter int unsigned SETTLE = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);

  logic              prev_q;
  logic [SETTLE-1:0] armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      armed_q <= '0;
    end else begin
      prev_q  <= lvl;
      armed_q <= {armed_q[SETTLE-2:0], 1'b1};
    end
  end

  assign rise = armed_q[SETTLE-1] &  lvl & ~prev_q;
  assign fall = armed_q[SETTLE-1] & ~lvl &  prev_q;

endmodule

// File: rtl/cdt_dead_timer.sv
module cdt_dead_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load)            cnt_q <= (load_val == '0) ? '0 : load_val - 1'b1;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/cdt_gate_ctrl.sv
module cdt_gate_ctrl
  import cdt_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          AUX_INV     = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_in,
  input  logic             en_in,
  input  logic             zvs_main,
  input  logic             zvs_aux,
  input  logic [CNT_W-1:0] t1_cycles,
  input  logic [CNT_W-1:0] t2_cycles,
  output logic             main_on,
  output logic             aux_drv,
  output logic             aux_oe
);

  localparam int unsigned SETTLE = SYNC_STAGES + 1;
  // bus order {zvs_aux, zvs_main, en, pwm}; enable resets high
  localparam logic [3:0]  SYNC_RST = 4'b0010;

  logic [3:0] sync_q;
  logic       pwm_s, en_s, zm_s, za_s;
  logic       rise_evt, fall_evt;
  logic       t_exp, t_load;
  logic [CNT_W-1:0] t_val;
  logic       t1_done, t2_done;
  cdt_state_e st_q, st_d;

  cdt_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({zvs_aux, zvs_main, en_in, pwm_in}),
    .q(sync_q)
  );

  assign {za_s, zm_s, en_s, pwm_s} = sync_q;

  cdt_edge #(.SETTLE(SETTLE)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(pwm_s),
    .rise(rise_evt), .fall(fall_evt)
  );

  cdt_dead_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .load(t_load), .load_val(t_val),
    .expired(t_exp)
  );

  assign t1_done = (st_q == ST_T1) && (t_exp || zm_s);
  assign t2_done = (st_q == ST_T2) && (t_exp || za_s);

  always_comb begin
    st_d   = st_q;
    t_load = 1'b0;
    t_val  = t1_cycles;
    if (!en_s) begin
      st_d = ST_SLEEP;
    end else if (st_q == ST_SLEEP) begin
      st_d = ST_IDLE;
    end else if (rise_evt) begin
      if (dly_skip(|t1_cycles, zm_s)) begin
        st_d = ST_MAIN;
      end else begin
        st_d   = ST_T1;
        t_load = 1'b1;
      end
    end else if (fall_evt) begin
      t_val = t2_cycles;
      if (dly_skip(|t2_cycles, za_s)) begin
        st_d = ST_AUX;
      end else begin
        st_d   = ST_T2;
        t_load = 1'b1;
      end
    end else if (t1_done) begin
      st_d = ST_MAIN;
    end else if (t2_done) begin
      st_d = ST_AUX;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign main_on = (st_q == ST_MAIN);
  assign aux_drv = aux_pin(st_q == ST_AUX, AUX_INV);
  assign aux_oe  = (st_q != ST_SLEEP);

endmodule

// File: rtl/cdt_gate_ctrl_chk.sv
module cdt_gate_ctrl_chk #(
  parameter bit AUX_INV = 1'b0
) (
  input logic clk,
  input logic rst_n,
  input logic main_on,
  input logic aux_drv,
  input logic aux_oe,
  input logic pwm_s,
  input logic en_s,
  input logic rise_evt,
  input logic fall_evt
);

  logic aux_act;
  assign aux_act = AUX_INV ? ~aux_drv : aux_drv;

  // R1: detected rising edge releases the auxiliary switch next cycle
  a_r1_aux_off_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt && en_s |=> !aux_act);

  // R1: main switch only turns on out of a high command
  a_r1_main_needs_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(main_on) |-> $past(pwm_s));

  // R2: detected falling edge drops the main switch next cycle
  a_r2_main_off_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> !main_on);

  // R2: auxiliary switch only turns on out of a low command
  a_r2_aux_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aux_act) |-> !$past(pwm_s));

  // R6: synchronized enable low forces sleep outputs next cycle
  a_r6_sleep_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> !main_on && !aux_oe && !aux_act);

  // R11: output-enable returns only after enable was seen high
  a_r11_wake_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aux_oe) |-> $past(en_s));

  // R12: no overlap of the two switches
  a_r12_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(main_on && aux_act));

endmodule

bind cdt_gate_ctrl cdt_gate_ctrl_chk #(.AUX_INV(AUX_INV)) u_chk (
  .clk(clk), .rst_n(rst_n), .main_on(main_on), .aux_drv(aux_drv),
  .aux_oe(aux_oe), .pwm_s(pwm_s), .en_s(en_s),
  .rise_evt(rise_evt), .fall_evt(fall_evt)
);

// File: tb/sim_cdt_gate_ctrl.sv
`timescale 1ns/1ps
module sim_cdt_gate_ctrl;

  localparam int CW  = 8;
  localparam int LIM = 400;
  // rows: t1, t2, expected main dead time, expected aux dead time
  localparam int TAB [6][4] = '{
    '{0, 0, 0, 0},
    '{1, 1, 1, 1},
    '{5, 12, 5, 12},
    '{12, 5, 12, 5},
    '{100, 3, 100, 3},
    '{10, 100, 10, 100}
  };

  logic clk = 1'b0;
  logic rst_n, pwm, en, zm, za;
  logic [CW-1:0] t1, t2;
  logic main0, drv0, oe0, main1, drv1, oe1;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  cdt_gate_ctrl #(.CNT_W(CW), .AUX_INV(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm), .en_in(en), .zvs_main(zm),
    .zvs_aux(za), .t1_cycles(t1), .t2_cycles(t2),
    .main_on(main0), .aux_drv(drv0), .aux_oe(oe0));

  cdt_gate_ctrl #(.CNT_W(CW), .AUX_INV(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm), .en_in(en), .zvs_main(zm),
    .zvs_aux(za), .t1_cycles(t1), .t2_cycles(t2),
    .main_on(main1), .aux_drv(drv1), .aux_oe(oe1));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic steps(input int k);
    for (int i = 0; i < k; i++) step();
  endtask

  function automatic logic sig(input int sel);
    return (sel == 0) ? main0 : drv0;
  endfunction

  // advance until the selected output reaches the wanted level, counting edges
  task automatic wait_sig(input int sel, input logic want, inout int n);
    while (sig(sel) != want && n < LIM) begin
      step();
      n++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    bit seen;
    rst_n = 1'b0; pwm = 1'b0; en = 1'b1; zm = 1'b0; za = 1'b0;
    t1 = 8'd4; t2 = 8'd4;
    steps(3);
    chk("R11 reset main_on", main0, 0);
    chk("R11 reset aux_oe", oe0, 1);
    chk("R7 reset aux_drv true", drv0, 0);
    chk("R7 reset aux_drv inverted", drv1, 1);
    rst_n = 1'b1;
    steps(5);
    chk("R11 idle after reset main_on", main0, 0);
    chk("R11 idle after reset aux", drv0, 0);

    // bring the block to auxiliary-on
    pwm = 1'b1; n = 0; wait_sig(0, 1'b1, n);
    steps(3);
    pwm = 1'b0; n = 0; wait_sig(1, 1'b1, n);
    steps(3);

    // table of dead-time pairs: R1 R2 R3 R10
    for (int i = 0; i < 6; i++) begin
      t1 = TAB[i][0][CW-1:0];
      t2 = TAB[i][1][CW-1:0];
      step();
      pwm = 1'b1; n = 0;
      wait_sig(1, 1'b0, n);
      chk($sformatf("R1 row%0d aux off latency", i), n, 3);
      wait_sig(0, 1'b1, n);
      chk($sformatf("R1 R10 row%0d main on latency", i), n, 3 + TAB[i][2]);
      chk($sformatf("R7 row%0d inverted pin", i), drv1, 1);
      steps(5);
      pwm = 1'b0; n = 0;
      wait_sig(0, 1'b0, n);
      chk($sformatf("R2 row%0d main off latency", i), n, 3);
      wait_sig(1, 1'b1, n);
      chk($sformatf("R2 R10 row%0d aux on latency", i), n, 3 + TAB[i][3]);
      chk($sformatf("R7 row%0d inverted pin low", i), drv1, 0);
      steps(5);
    end

    // R4: detect input ends the main wait
    t1 = 8'd50;
    pwm = 1'b1; steps(5);
    zm = 1'b1; steps(2);
    chk("R4 main still off before detect settles", main0, 0);
    step();
    chk("R4 main on from detect", main0, 1);
    zm = 1'b0; steps(4);

    // R5: detect input ends the auxiliary wait
    t2 = 8'd50;
    pwm = 1'b0; steps(5);
    za = 1'b1; steps(2);
    chk("R5 aux still off before detect settles", drv0, 0);
    step();
    chk("R5 aux on from detect", drv0, 1);
    za = 1'b0; steps(4);

    // R3: value latched at interval start
    t1 = 8'd10; t2 = 8'd6;
    pwm = 1'b1; n = 0;
    steps(4); n = 4;
    t1 = 8'd100;
    wait_sig(0, 1'b1, n);
    chk("R3 running wait keeps old count", n, 13);
    steps(2);
    pwm = 1'b0; n = 0; wait_sig(1, 1'b1, n);
    chk("R3 aux wait", n, 9);
    steps(2);
    pwm = 1'b1; n = 0; wait_sig(0, 1'b1, n);
    chk("R3 new count used next interval", n, 103);
    steps(2);
    pwm = 1'b0; n = 0; wait_sig(1, 1'b1, n);
    steps(3);

    // R8: fall during the main wait
    t1 = 8'd40; t2 = 8'd4;
    pwm = 1'b1; steps(10);
    pwm = 1'b0; n = 0; seen = 1'b0;
    while (drv0 != 1'b1 && n < LIM) begin
      step(); n++;
      if (main0) seen = 1'b1;
    end
    chk("R8 aux wait from the fall", n, 7);
    for (int i = 0; i < 50; i++) begin
      step();
      if (main0) seen = 1'b1;
    end
    chk("R8 main never on", seen, 0);

    // R9: rise during the auxiliary wait
    t1 = 8'd3; t2 = 8'd40;
    pwm = 1'b1; n = 0; wait_sig(0, 1'b1, n);
    steps(5);
    pwm = 1'b0; steps(10);
    pwm = 1'b1; n = 0; seen = 1'b0;
    while (main0 != 1'b1 && n < LIM) begin
      step(); n++;
      if (drv0) seen = 1'b1;
    end
    chk("R9 main wait from the rise", n, 6);
    for (int i = 0; i < 50; i++) begin
      step();
      if (drv0) seen = 1'b1;
    end
    chk("R9 aux stays off", seen, 0);

    // R6: sleep while the main switch is on
    t2 = 8'd4;
    en = 1'b0; steps(2);
    chk("R6 main held before enable settles", main0, 1);
    step();
    chk("R6 sleep main_on", main0, 0);
    chk("R6 sleep aux_oe", oe0, 0);
    chk("R7 sleep level true", drv0, 0);
    chk("R7 sleep level inverted", drv1, 1);
    pwm = 1'b0; steps(10);
    pwm = 1'b1; steps(10);
    chk("R6 PWM ignored main_on", main0, 0);
    chk("R6 PWM ignored aux_oe", oe0 | oe1, 0);
    chk("R6 PWM ignored aux", drv0, 0);

    // R11: wake with PWM already high
    en = 1'b1; steps(2);
    chk("R11 still asleep", oe0, 0);
    step();
    chk("R11 wake aux_oe", oe0, 1);
    chk("R11 wake aux off", drv0, 0);
    steps(30);
    chk("R11 no edge no main", main0, 0);
    pwm = 1'b0; n = 0; wait_sig(1, 1'b1, n);
    chk("R11 first fall after wake", n, 7);
    steps(3);

    // R11: reset mid-run with PWM high
    pwm = 1'b1; n = 0; wait_sig(0, 1'b1, n);
    rst_n = 1'b0; #1;
    chk("R11 reset clears main", main0, 0);
    steps(2);
    rst_n = 1'b1; steps(30);
    chk("R11 main stays off after reset", main0, 0);
    chk("R11 aux_oe after reset", oe0, 1);
    pwm = 1'b0; n = 0; wait_sig(1, 1'b1, n);
    chk("R11 fall after reset", n, 7);
    chk("R12 exclusive at end", main0 & drv0, 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule